// File: doc/BRIEF.md
# Odd/Even 50% Duty Clock Divider

This block divides a fast input clock by 3, 4, 5 or 6 and produces an output whose high and low phases are equal for every ratio. Even ratios are built from a rising-edge counter alone. Odd ratios add a falling-edge copy of the counter's high phase, which stretches the high time by half an input cycle, so the result is exactly K/2 input cycles high and K/2 input cycles low.

The divided clock feeds two identical output channels. Each channel has a true signal and a complement signal. An active-high asynchronous master reset holds the dividers, drives every true output low and every complement output high. A new ratio on the select input is taken only when the current output period ends, so a change of ratio never produces a shortened or stretched phase. The valid input range is 620 to 780 MHz, which gives outputs of roughly 103 to 260 MHz.

Top module: `clkdiv_oe`

## Requirements
- R1: The select input picks the ratio K as 3 + sel: 00 gives 3, 01 gives 4, 10 gives 5 and 11 gives 6. Each output period lasts 2K input half-cycles.
- R2: For every ratio the output is high for exactly K input half-cycles and low for exactly K input half-cycles. For odd K the output falls on an input falling edge.
- R3: Both channels carry the same waveform at all times, and each complement output is the inverse of its true output.
- R4: While mr_i is high, every true output is low and every complement output is high. This takes effect at once, without waiting for a clock edge, and holds whatever the select input does.
- R5: After mr_i falls, the outputs rise on the first rising input edge. The ratio used for that first period is the select value sampled on that edge.
- R6: A select change made during an output period has no effect until that period's terminal count. The current period completes with the old ratio, and the next period uses the new one.
- R7: The internal period counter never reaches or passes the active ratio K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock (both edges used) |
| mr_i | input | 1 | Active-high asynchronous master reset |
| sel_i | input | 2 | Ratio select, K = 3 + sel_i |
| clk_o | output | 2 | Divided clock, true polarity, one bit per channel |
| clk_no | output | 2 | Divided clock, complement polarity, one bit per channel |

## Verification
On every cycle, assertions check the following:
- The reset values of the outputs.
- The counter range.
- That the latched ratio stays put between terminal counts.
- That the rising-edge phase rises only at count zero.
- That the first edge after reset release starts a high phase.

Only the bench scenarios can show the properties that need a whole waveform. These are the exact high and low durations in input half-cycles for each ratio, the sequence of periods around a mid-period ratio change, and the immediate (edge-free) response to reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int BASE_DIV = 3;
  localparam int SEL_W    = 2;

  function automatic int max_ratio(input int base, input int sel_w);
    return base + (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
  parameter int SEL_W = 2,
  parameter int BASE  = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             mr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pos_o,
  output logic             odd_o
);
  logic [SEL_W-1:0] ratio_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, k_cur, k_new, half_nxt;
  logic             started_q, pos_q, wrap;

  assign k_cur    = CNT_W'(BASE) + CNT_W'(ratio_q);
  assign k_new    = CNT_W'(BASE) + CNT_W'(sel_i);
  // first edge after reset behaves as a terminal count
  assign wrap     = !started_q || (cnt_q == k_cur - CNT_W'(1));
  assign cnt_nxt  = wrap ? '0 : cnt_q + CNT_W'(1);
  assign half_nxt = wrap ? (k_new >> 1) : (k_cur >> 1);

  always_ff @(posedge clk_i or posedge mr_i) begin
    if (mr_i) begin
      ratio_q   <= '0;
      cnt_q     <= '0;
      started_q <= 1'b0;
      pos_q     <= 1'b0;
    end else begin
      started_q <= 1'b1;
      cnt_q     <= cnt_nxt;
      pos_q     <= (cnt_nxt < half_nxt);
      if (wrap) ratio_q <= sel_i;
    end
  end

  assign pos_o = pos_q;
  assign odd_o = k_cur[0];

  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (mr_i)
    cnt_q < k_cur);
  a_r6_ratio_hold: assert property (@(posedge clk_i) disable iff (mr_i)
    (started_q && cnt_q != k_cur - CNT_W'(1)) |=> $stable(ratio_q));
  a_r6_rise_at_wrap: assert property (@(posedge clk_i) disable iff (mr_i)
    $rose(pos_q) |-> (cnt_q == '0));
  a_r5_first_rise: assert property (@(posedge clk_i) disable iff (mr_i)
    !started_q |=> pos_q);
endmodule

// File: rtl/clkdiv_halfcycle.sv
module clkdiv_halfcycle (
  input  logic clk_i,
  input  logic mr_i,
  input  logic pos_i,
  input  logic odd_i,
  output logic out_o
);
  logic neg_q;

  // half-cycle delayed copy, only used for odd ratios
  always_ff @(negedge clk_i or posedge mr_i) begin
    if (mr_i) neg_q <= 1'b0;
    else      neg_q <= pos_i & odd_i;
  end

  assign out_o = pos_i | neg_q;

  a_r2_neg_inside_pos: assert property (@(posedge clk_i) disable iff (mr_i)
    $rose(neg_q) |-> pos_i);
endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout #(
  parameter int N_CH = 2
) (
  input  logic            src_i,
  output logic [N_CH-1:0] clk_o,
  output logic [N_CH-1:0] clk_no
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign clk_o[i]  = src_i;
    assign clk_no[i] = ~src_i;
  end
endmodule

// File: rtl/clkdiv_oe.sv
module clkdiv_oe
  import clkdiv_pkg::*;
#(
  parameter int N_CH  = 2,
  parameter int SW    = SEL_W,
  parameter int BASE  = BASE_DIV
) (
  input  logic            clk_i,
  input  logic            mr_i,
  input  logic [SW-1:0]   sel_i,
  output logic [N_CH-1:0] clk_o,
  output logic [N_CH-1:0] clk_no
);
  localparam int CNT_W = $clog2(max_ratio(BASE, SW) + 1);

  logic pos, odd, div_clk;

  clkdiv_count #(.SEL_W(SW), .BASE(BASE), .CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .mr_i(mr_i), .sel_i(sel_i), .pos_o(pos), .odd_o(odd)
  );

  clkdiv_halfcycle u_half (
    .clk_i(clk_i), .mr_i(mr_i), .pos_i(pos), .odd_i(odd), .out_o(div_clk)
  );

  clkdiv_fanout #(.N_CH(N_CH)) u_fan (
    .src_i(div_clk), .clk_o(clk_o), .clk_no(clk_no)
  );

  a_r4_reset_out: assert property (@(posedge clk_i)
    mr_i |-> (clk_o == '0 && clk_no == '1));
endmodule

// File: tb/clkdiv_oe_tb.sv
module clkdiv_oe_tb;
  logic       clk = 1'b0;
  logic       mr;
  logic [1:0] sel;
  logic [1:0] clk_o, clk_no;
  int checks = 0, failures = 0;
  bit bad_ch = 0;

  clkdiv_oe u_dut (.clk_i(clk), .mr_i(mr), .sel_i(sel), .clk_o(clk_o), .clk_no(clk_no));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance to 1 ns after the next clock edge, checking channel consistency (R3)
  task automatic step();
    @(clk);
    #1;
    if (clk_o[0] !== clk_o[1] || clk_no !== ~clk_o) bad_ch = 1;
  endtask

  // starts at first high sample of a period, ends at first high sample of the next
  task automatic run_periods(input int k, input int n, input string tag);
    for (int p = 0; p < n; p++) begin
      int h = 0;
      int l = 0;
      while (clk_o[0] === 1'b1 && h < 20) begin h++; step(); end
      while (clk_o[0] === 1'b0 && l < 20) begin l++; step(); end
      chk(h == k, {tag, " high half-cycles"}, h, k);
      chk(l == k, {tag, " low half-cycles"}, l, k);
    end
    chk(!bad_ch, "R3 channels/complements consistent", int'(bad_ch), 0);
    bad_ch = 0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mr  = 1'b1;
    sel = 2'b00;
    repeat (4) step();
    chk(clk_o == 2'b00 && clk_no == 2'b11, "R4 reset state", int'({clk_o, clk_no}), 3);

    // R1 R2 R5 R7: every ratio from reset release
    for (int s = 0; s < 4; s++) begin
      mr  = 1'b1;
      sel = 2'(s);
      repeat (4) step();
      chk(clk_o == 2'b00 && clk_no == 2'b11, "R4 held in reset", int'({clk_o, clk_no}), 3);
      if (clk !== 1'b0) step();
      mr = 1'b0;
      chk(clk_o[0] == 1'b0, "R5 low before first edge", int'(clk_o[0]), 0);
      step();
      chk(clk_o[0] == 1'b1, "R5 rise on first edge", int'(clk_o[0]), 1);
      run_periods(s + 3, 4, "R1 R2 R7 ratio");
    end

    // R6: changes take effect only after the current period
    sel = 2'b00;
    run_periods(6, 1, "R6 old ratio 6 completes");
    run_periods(3, 3, "R6 new ratio 3");
    sel = 2'b10;
    run_periods(3, 1, "R6 old ratio 3 completes");
    run_periods(5, 3, "R6 new ratio 5");
    sel = 2'b01;
    run_periods(5, 1, "R6 old ratio 5 completes");
    run_periods(4, 2, "R6 new ratio 4");

    // R4: asynchronous reset mid-period, select activity ignored
    step(); step(); step();
    #0.5;
    mr = 1'b1;
    #0.5;
    chk(clk_o == 2'b00 && clk_no == 2'b11, "R4 immediate reset", int'({clk_o, clk_no}), 3);
    begin
      bit held = 1;
      for (int i = 0; i < 8; i++) begin
        sel = 2'(i);
        step();
        if (clk_o !== 2'b00 || clk_no !== 2'b11) held = 0;
      end
      chk(held, "R4 reset holds with select toggling", int'(held), 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule